// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Sequencer

This block produces one active-low reset for a processor from three sources: a supply-good flag from an outside comparator, a watchdog that software keeps alive with strobes, and a raw push-button reset that is active low. A supply fault pulls the reset low in the same cycle it appears. When the supply comes back, the reset is held low for a fixed hold time. A watchdog that is not serviced, or a debounced button press, also starts a reset pulse that lasts at least the hold time.

The hold time, the watchdog timeout and the debounce length are all parameters in clock cycles. The strobe flag and the raw button input each pass through a two-flop synchronizer. The block also reports which source holds the reset, as a two-bit cause code. If strobes stay absent, the block does not latch in reset. Instead it sends a fresh pulse of hold-time width after every timeout period.

Top module: `sup_rst_seq`

## Requirements
- R1: While `supply_ok_i` is 0, `rst_n_o` is 0 in that same cycle and `cause_o` reads 1 (supply).
- R2: After `supply_ok_i` returns to 1, `rst_n_o` rises exactly HOLD_CYC clock edges after the first edge that samples it high.
- R3: While `rst` is high, `rst_n_o` is 0 and `cause_o` is 1. After `rst` falls with the supply good, `rst_n_o` rises HOLD_CYC edges later.
- R4: With no strobes, `rst_n_o` stays high for exactly TMO_CYC cycles and then low for exactly HOLD_CYC cycles. This pattern repeats, and `cause_o` reads 2 (watchdog) during each low phase.
- R5: A one-cycle strobe given at the S-th high cycle after a release restarts the timeout. The high phase then lasts S+2+TMO_CYC cycles, the extra two being synchronizer latency.
- R6: Strobes that arrive while `rst_n_o` is low have no effect. The low phase still lasts HOLD_CYC cycles, and the next high phase lasts TMO_CYC cycles.
- R7: A low pulse on `ext_rst_n_i` shorter than DEB_CYC cycles leaves `rst_n_o` high.
- R8: A low pulse on `ext_rst_n_i` of L >= DEB_CYC cycles drives `rst_n_o` low DEB_CYC+2 edges after it starts. The low phase lasts L+HOLD_CYC-1 cycles, so a long press keeps the reset low until release plus the hold time. `cause_o` reads 3 (external) during this low phase.
- R9: A supply fault during any pulse or running phase aborts it, and the full HOLD_CYC hold restarts when the supply recovers.
- R10: `cause_o` is 0 exactly while `rst_n_o` is high, and it is nonzero while `rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| supply_ok_i | input | 1 | Supply within tolerance (from an outside comparator) |
| strobe_i | input | 1 | Watchdog strobe detected, asynchronous |
| ext_rst_n_i | input | 1 | Raw external reset, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low |
| cause_o | output | 2 | Reset source: 0 none, 1 supply, 2 watchdog, 3 external |

## Verification
A wrong hold or timeout counter shows at the ports as a low or high phase that is off by one or more cycles. This appears within a single watchdog period, because every phase length is measured cycle by cycle against HOLD_CYC and TMO_CYC. A debounce counter that does not clear when the input matches shows up as a glitch that is accepted, or as a reset that starts at the wrong edge. A stale cause register shows as a wrong code during the very first low cycle. Strobe handling during reset shows in the length of the next high phase.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Reset source reported on the cause output
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_SUPPLY = 2'd1,
        CAUSE_WDOG   = 2'd2,
        CAUSE_EXT    = 2'd3
    } cause_e;

    // Sequencer phase: holding reset, or running with the watchdog armed
    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Asynchronous inputs that share one synchronizer
    typedef struct packed {
        logic strobe;
        logic ext_n;
    } sync_bus_t;

    // Width of a counter that must hold values 0 .. n-1
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned     W       = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic meta;
            logic stab;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta <= RST_VAL[gi];
                    stab <= RST_VAL[gi];
                end else begin
                    meta <= d[gi];
                    stab <= meta;
                end
            end
            assign q[gi] = stab;
        end
    endgenerate

endmodule

// File: rtl/sup_debounce.sv
module sup_debounce
    import sup_pkg::*;
#(
    parameter int unsigned DEB_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_n,
    output logic pressed
);

    localparam int unsigned CW = cnt_w(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic          level_n;
    logic [CW-1:0] run_cnt;

    // A new level is taken only after DEB_CYC consecutive samples that differ
    always_ff @(posedge clk) begin
        if (rst) begin
            level_n <= 1'b1;
            run_cnt <= '0;
        end else if (raw_n == level_n) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            level_n <= raw_n;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign pressed = ~level_n;

endmodule

// File: rtl/sup_seq.sv
module sup_seq
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 500_000,
    parameter int unsigned TMO_CYC  = 700_000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   supply_ok,
    input  logic   strobe,
    input  logic   pressed,
    output logic   rst_n,
    output cause_e cause
);

    localparam int unsigned HW = cnt_w(HOLD_CYC);
    localparam int unsigned TW = cnt_w(TMO_CYC);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        cause_e        why;
        logic [HW-1:0] hold;
        logic [TW-1:0] wd;
    } seq_t;

    localparam seq_t SEQ_RST = '{ph: PH_HOLD, why: CAUSE_SUPPLY, hold: '0, wd: '0};

    seq_t cur, nxt;

    always_comb begin
        nxt = cur;
        if (!supply_ok) begin
            // supply fault wins over everything and restarts the hold
            nxt.ph   = PH_HOLD;
            nxt.why  = CAUSE_SUPPLY;
            nxt.hold = '0;
        end else begin
            unique case (cur.ph)
                PH_HOLD: begin
                    if (pressed) begin
                        nxt.why  = CAUSE_EXT;
                        nxt.hold = '0;
                    end else if (cur.hold == HOLD_LAST) begin
                        nxt.ph = PH_RUN;
                        nxt.wd = '0;
                    end else begin
                        nxt.hold = cur.hold + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (pressed) begin
                        nxt.ph   = PH_HOLD;
                        nxt.why  = CAUSE_EXT;
                        nxt.hold = '0;
                    end else if (strobe) begin
                        nxt.wd = '0;
                    end else if (cur.wd == TMO_LAST) begin
                        nxt.ph   = PH_HOLD;
                        nxt.why  = CAUSE_WDOG;
                        nxt.hold = '0;
                    end else begin
                        nxt.wd = cur.wd + 1'b1;
                    end
                end
                default: nxt = SEQ_RST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= SEQ_RST;
        else     cur <= nxt;
    end

    // Supply path is combinational so a fault shows in the same cycle
    assign rst_n = supply_ok & (cur.ph == PH_RUN);

    always_comb begin
        if (!supply_ok)           cause = CAUSE_SUPPLY;
        else if (cur.ph == PH_RUN) cause = CAUSE_NONE;
        else                      cause = cur.why;
    end

endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 500_000,
    parameter int unsigned TMO_CYC  = 700_000,
    parameter int unsigned DEB_CYC  = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok_i,
    input  logic       strobe_i,
    input  logic       ext_rst_n_i,
    output logic       rst_n_o,
    output logic [1:0] cause_o
);

    localparam sync_bus_t SYNC_RST = '{strobe: 1'b0, ext_n: 1'b1};

    sync_bus_t raw_bus;
    sync_bus_t syn_bus;
    logic      ext_pressed;
    cause_e    seq_cause;

    assign raw_bus = '{strobe: strobe_i, ext_n: ext_rst_n_i};

    sup_sync #(
        .W       ($bits(sync_bus_t)),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (syn_bus)
    );

    sup_debounce #(
        .DEB_CYC (DEB_CYC)
    ) u_deb (
        .clk     (clk),
        .rst     (rst),
        .raw_n   (syn_bus.ext_n),
        .pressed (ext_pressed)
    );

    sup_seq #(
        .HOLD_CYC (HOLD_CYC),
        .TMO_CYC  (TMO_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok_i),
        .strobe    (syn_bus.strobe),
        .pressed   (ext_pressed),
        .rst_n     (rst_n_o),
        .cause     (seq_cause)
    );

    assign cause_o = seq_cause;

endmodule

// File: rtl/sup_rst_seq_chk.sv
module sup_rst_seq_chk
    import sup_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 500_000
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok_i,
    input logic       rst_n_o,
    input logic [1:0] cause_o,
    input logic       pressed
);

    localparam int unsigned LW = cnt_w(HOLD_CYC + 2);

    // Length of the current low phase, saturating at HOLD_CYC
    logic [LW-1:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst)                     lo_run <= '0;
        else if (rst_n_o)            lo_run <= '0;
        else if (lo_run < LW'(HOLD_CYC)) lo_run <= lo_run + 1'b1;
    end

    AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |-> (!rst_n_o && cause_o == 2'd1)); // R1

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && !$past(rst_n_o)) |-> (lo_run >= LW'(HOLD_CYC))); // R2

    AST_PRESS_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        pressed |=> !rst_n_o); // R8

    AST_CAUSE_NONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        rst_n_o |-> (cause_o == 2'd0)); // R10

    AST_CAUSE_SET_LOW: assert property (@(posedge clk) disable iff (rst)
        !rst_n_o |-> (cause_o != 2'd0)); // R10

endmodule

bind sup_rst_seq sup_rst_seq_chk #(
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .rst_n_o     (rst_n_o),
    .cause_o     (cause_o),
    .pressed     (ext_pressed)
);

// File: tb/sup_rst_seq_tb.sv
`timescale 1ns/1ps
module sup_rst_seq_tb;

    localparam int HOLD = 8;
    localparam int TMO  = 20;
    localparam int DEB  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok_i = 1'b1;
    logic       strobe_i = 1'b0;
    logic       ext_rst_n_i = 1'b1;
    logic       rst_n_o;
    logic [1:0] cause_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    sup_rst_seq #(
        .HOLD_CYC (HOLD),
        .TMO_CYC  (TMO),
        .DEB_CYC  (DEB)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .supply_ok_i (supply_ok_i),
        .strobe_i    (strobe_i),
        .ext_rst_n_i (ext_rst_n_i),
        .rst_n_o     (rst_n_o),
        .cause_o     (cause_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Number of samples from the current one until the first high sample (inclusive)
    task automatic count_until_high(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_n_o && n < 1000);
    endtask

    // Called on a high sample; counts the high samples including this one
    task automatic measure_high(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (rst_n_o && n < 1000) n++;
            else break;
        end
    endtask

    // Called on a low sample; counts the low samples including this one
    task automatic measure_low(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (!rst_n_o && n < 1000) n++;
            else break;
        end
    endtask

    // Leaves the bench on the first high sample after a low phase
    task automatic wait_rise();
        int g = 0;
        while (rst_n_o && g < 1000) begin @(negedge clk); g++; end
        while (!rst_n_o && g < 1000) begin @(negedge clk); g++; end
    endtask

    initial begin
        int n;
        int m;

        // R3: state under reset and release
        repeat (4) @(negedge clk);
        check(rst_n_o == 1'b0, "R3 low in reset", rst_n_o, 0);
        check(cause_o == 2'd1, "R3 cause in reset", cause_o, 1);
        rst = 1'b0;
        count_until_high(n);
        check(n == HOLD, "R3 power-on hold", n, HOLD);

        // R4: free-running watchdog pulses
        for (int p = 0; p < 3; p++) begin
            measure_high(n);
            check(n == TMO, "R4 high phase", n, TMO);
            check(cause_o == 2'd2, "R4 cause wdog", cause_o, 2);
            measure_low(m);
            check(m == HOLD, "R4 low phase", m, HOLD);
        end

        // R5: strobe at every offset of the high phase
        for (int s = 1; s <= TMO - 3; s++) begin
            n = 1;
            forever begin
                if (n == s) strobe_i = 1'b1;
                @(negedge clk);
                strobe_i = 1'b0;
                if (rst_n_o && n < 1000) n++;
                else break;
            end
            check(n == s + 2 + TMO, "R5 strobe restarts timeout", n, s + 2 + TMO);
            measure_low(m);
            check(m == HOLD, "R5 following low", m, HOLD);
        end

        // R6: strobes during a low phase are ignored
        measure_high(n);
        n = 1;
        forever begin
            strobe_i = (n <= HOLD - 3) && (n % 2 == 1);
            @(negedge clk);
            strobe_i = 1'b0;
            if (!rst_n_o && n < 1000) n++;
            else break;
        end
        check(n == HOLD, "R6 low unchanged by strobes", n, HOLD);
        measure_high(n);
        check(n == TMO, "R6 timeout from zero", n, TMO);
        measure_low(m);

        // R7, R8: external pulse length sweep, including a long press
        for (int k = 1; k <= DEB + 4; k++) begin
            int len;
            int lows;
            int first_w;
            int first_c;
            int win;
            int exp_lows;
            len = (k == DEB + 4) ? HOLD + 10 : k;
            wait_rise();
            win = len + DEB + HOLD + 2;
            lows = 0;
            first_w = -1;
            first_c = -1;
            ext_rst_n_i = 1'b0;
            for (int w = 0; w < win; w++) begin
                if (w == len) ext_rst_n_i = 1'b1;
                @(negedge clk);
                if (!rst_n_o) begin
                    if (lows == 0) begin
                        first_w = w;
                        first_c = int'(cause_o);
                    end
                    lows++;
                end
            end
            ext_rst_n_i = 1'b1;
            exp_lows = (len < DEB) ? 0 : len + HOLD - 1;
            if (len < DEB) begin
                check(lows == 0, "R7 short glitch ignored", lows, 0);
            end else begin
                check(lows == exp_lows, "R8 external low length", lows, exp_lows);
                check(first_w == DEB + 2, "R8 external start edge", first_w, DEB + 2);
                check(first_c == 3, "R8 cause external", first_c, 3);
            end
        end

        // R1, R2, R9: supply faults during running and during a watchdog pulse
        for (int mode = 0; mode < 2; mode++) begin
            for (int k = 1; k <= 3; k++) begin
                wait_rise();
                if (mode == 0) begin
                    repeat (5) @(negedge clk);
                end else begin
                    while (rst_n_o) @(negedge clk);
                    repeat (3) @(negedge clk);
                end
                supply_ok_i = 1'b0;
                #1;
                check(rst_n_o == 1'b0, "R1 immediate low", rst_n_o, 0);
                check(cause_o == 2'd1, "R1 cause supply", cause_o, 1);
                repeat (k) @(negedge clk);
                check(rst_n_o == 1'b0, "R1 low while fault", rst_n_o, 0);
                supply_ok_i = 1'b1;
                count_until_high(n);
                check(n == HOLD, "R9 R2 full hold after recovery", n, HOLD);
                measure_high(n);
                check(n == TMO, "R10 run after supply hold", n, TMO);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule